// File: doc/BRIEF.md
# GPIO port register block

This block is the register side of a general-purpose I/O port with up to sixteen pins, reached through a small 32-bit register bus. The bus has a select, a write strobe and a word index. Each pin owns a 4-bit configuration field. The two low bits of the field choose input (00) or an output speed (any non-zero value). The two high bits choose the input flavour or the output driver type. From these fields and from the output data bits, the block drives per-pin output enable, open-drain select, alternate-function select, pull enable and pull direction. It also returns the pin inputs to software through a synchronizer.

Software updates the output bits in three ways: a plain write of the output data word, an atomic set/clear word, and a clear-only word. A three-write key sequence on the lock register freezes a chosen subset of pin configuration fields until the next reset. A sequence that is broken or out of order does nothing.

Word indices: 0 low configuration (pins 0–7), 1 high configuration (pins 8–15), 2 input data, 3 output data, 4 set/clear, 5 clear-only, 6 lock. Reads return data combinationally in the cycle the word index is presented. Writes take effect at the clock edge.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset both configuration words read 0x44444444 (every pin a floating input), output data reads 0, lock reads 0, and all pin drive outputs are 0. Word index 7 reads 0.
- R2: The field for pin n lives in word 0 when n<8 and word 1 otherwise, at bits [4*(n mod 8)+3 : 4*(n mod 8)]. Configuration words read back what was written.
- R3: A field with a non-zero mode (bits [1:0]) makes the pin an output, and pin_oe is 1. In that case drive-type bit 2 set selects open-drain (pin_od), and drive-type bit 3 set selects the alternate function (pin_alt).
- R4: With mode 00, drive-type 10 enables the pull (pin_pull_en). The pin's output data bit then picks the direction (1 up, 0 down) on pin_pull_up. Drive-types 00 and 01 leave the pull off.
- R5: A write to word 3 loads output data bits [15:0], which read back and appear on pin_out.
- R6: A write to word 4 sets the output bits marked in wdata[15:0] and clears those marked in wdata[31:16]. Zero bits change nothing, and set wins when both are marked. Word 4 reads 0.
- R7: A write to word 5 clears the output bits marked in wdata[15:0]. Word 5 reads 0.
- R8: Word 2 reads the pin inputs through a two-stage synchronizer. A change is visible after the second rising edge and not before. Bits [31:16] read 0.
- R9: Three writes to word 6 lock the pins in wdata[15:0] when they carry the same mask in wdata[15:0], with wdata[16] = 1, then 0, then 1, and no other access between them. Word 6 then reads 1 in bit 16 and the mask in [15:0]. Locked fields ignore configuration writes, and unlocked fields still accept them.
- R10: A wrong key, a different mask, or any other access within the sequence aborts it. Lock then reads 0 and every field stays writable.
- R11: Once locked, further lock sequences change nothing until reset, and reset clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pin_in | input | NPIN | Raw pin inputs |
| pin_out | output | NPIN | Output data value per pin |
| pin_oe | output | NPIN | Output enable per pin |
| pin_od | output | NPIN | Open-drain select per pin |
| pin_alt | output | NPIN | Alternate-function select per pin |
| pin_pull_en | output | NPIN | Pull resistor enable per pin |
| pin_pull_up | output | NPIN | Pull direction, 1 = up |

## Verification
The bench builds the block with its default parameters: sixteen pins and two synchronizer stages. With these values both configuration words are fully populated, so every field position in the low and the high word can be written and read. The exact two-edge input latency can also be probed cycle by cycle. The sixteen-pin mask fills the whole lock field, so the lock tests can mix locked and unlocked pins in one configuration word.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
    localparam int REG_W        = 32;
    localparam int FIELD_W      = 4;
    localparam int PINS_PER_REG = REG_W / FIELD_W;
    localparam int WIDX_W       = 3;
    localparam int KEY_BIT      = 16;
    localparam int CLR_SHIFT    = 16;
    localparam logic [FIELD_W-1:0] CFG_RESET = 4'h4;

    typedef enum logic [WIDX_W-1:0] {
        A_CFG_LO = 3'd0,
        A_CFG_HI = 3'd1,
        A_IN     = 3'd2,
        A_OUT    = 3'd3,
        A_SETCLR = 3'd4,
        A_BITCLR = 3'd5,
        A_LOCK   = 3'd6
    } reg_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[0] <= '0;
                    else        stg_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_lock_seq.sv
module gpio_lock_seq #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_i,
    input  logic            wr_i,
    input  logic            lock_sel_i,
    input  logic            key_i,
    input  logic [NPIN-1:0] mask_i,
    output logic            locked_o,
    output logic [NPIN-1:0] mask_o
);
    typedef enum logic [1:0] {L_IDLE, L_ARM1, L_ARM2, L_DONE} lk_state_e;
    typedef struct packed {
        lk_state_e       st;
        logic [NPIN-1:0] mask;
    } lk_t;

    lk_t lk_d, lk_q;
    logic lock_wr;

    assign lock_wr = acc_i && wr_i && lock_sel_i;

    always_comb begin
        lk_d = lk_q;
        if (acc_i) begin
            case (lk_q.st)
                L_IDLE: if (lock_wr && key_i) begin
                    lk_d.st   = L_ARM1;
                    lk_d.mask = mask_i;
                end
                L_ARM1: lk_d.st = (lock_wr && !key_i && mask_i == lk_q.mask) ? L_ARM2 : L_IDLE;
                L_ARM2: lk_d.st = (lock_wr &&  key_i && mask_i == lk_q.mask) ? L_DONE : L_IDLE;
                default: lk_d = lk_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '{st: L_IDLE, mask: '0};
        else        lk_q <= lk_d;
    end

    assign locked_o = (lk_q.st == L_DONE);
    assign mask_o   = locked_o ? lk_q.mask : '0;

    // R11
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> (locked_o && $stable(mask_o)));

    // R9
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(lock_wr && key_i));
endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
    import gpio_regs_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic [NPIN*FIELD_W-1:0] cfg_i,
    input  logic [NPIN-1:0]         odr_i,
    output logic [NPIN-1:0]         oe_o,
    output logic [NPIN-1:0]         od_o,
    output logic [NPIN-1:0]         alt_o,
    output logic [NPIN-1:0]         pull_en_o,
    output logic [NPIN-1:0]         pull_up_o
);
    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_pin
            logic [1:0] mode;
            logic [1:0] cnf;
            logic       is_out;
            assign mode         = cfg_i[g*FIELD_W +: 2];
            assign cnf          = cfg_i[g*FIELD_W + 2 +: 2];
            assign is_out       = |mode;
            assign oe_o[g]      = is_out;
            assign od_o[g]      = is_out && cnf[0];
            assign alt_o[g]     = is_out && cnf[1];
            assign pull_en_o[g] = !is_out && (cnf == 2'b10);
            assign pull_up_o[g] = pull_en_o[g] && odr_i[g];
        end
    endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_regs_pkg::*;
#(
    parameter int NPIN        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [WIDX_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_od,
    output logic [NPIN-1:0]   pin_alt,
    output logic [NPIN-1:0]   pin_pull_en,
    output logic [NPIN-1:0]   pin_pull_up
);
    localparam int CFG_BITS = NPIN * FIELD_W;
    localparam int PAD_W    = 2 * REG_W;

    typedef struct packed {
        logic [CFG_BITS-1:0] cfg;
        logic [NPIN-1:0]     odr;
    } port_t;

    port_t st_d, st_q;
    logic               wr_hit;
    logic               locked;
    logic [NPIN-1:0]    lock_mask;
    logic [NPIN-1:0]    in_sync;
    logic [PAD_W-1:0]   cfg_pad;
    logic [CFG_BITS-1:0] lk_fld;
    logic               hi_sel;
    logic [NPIN-1:0]    set_bits, clr_bits;

    assign wr_hit   = bus_sel && bus_wr;
    assign hi_sel   = (bus_addr == A_CFG_HI);
    assign set_bits = bus_wdata[NPIN-1:0];
    assign clr_bits = bus_wdata[CLR_SHIFT +: NPIN];

    gpio_in_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst_n (rst_n), .d (pin_in), .q (in_sync)
    );

    gpio_lock_seq #(.NPIN(NPIN)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_i      (bus_sel),
        .wr_i       (bus_wr),
        .lock_sel_i (bus_addr == A_LOCK),
        .key_i      (bus_wdata[KEY_BIT]),
        .mask_i     (bus_wdata[NPIN-1:0]),
        .locked_o   (locked),
        .mask_o     (lock_mask)
    );

    gpio_pin_decode #(.NPIN(NPIN)) u_dec (
        .cfg_i     (st_q.cfg),
        .odr_i     (st_q.odr),
        .oe_o      (pin_oe),
        .od_o      (pin_od),
        .alt_o     (pin_alt),
        .pull_en_o (pin_pull_en),
        .pull_up_o (pin_pull_up)
    );

    // next-state
    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            case (bus_addr)
                A_CFG_LO, A_CFG_HI: begin
                    for (int g = 0; g < NPIN; g++) begin
                        if (!lock_mask[g] && ((g >= PINS_PER_REG) == hi_sel))
                            st_d.cfg[g*FIELD_W +: FIELD_W] =
                                bus_wdata[(g % PINS_PER_REG)*FIELD_W +: FIELD_W];
                    end
                end
                A_OUT:    st_d.odr = set_bits;
                A_SETCLR: st_d.odr = (st_q.odr & ~clr_bits) | set_bits;
                A_BITCLR: st_d.odr = st_q.odr & ~set_bits;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= {NPIN{CFG_RESET}};
            st_q.odr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read path
    assign cfg_pad = PAD_W'(st_q.cfg);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                A_CFG_LO: bus_rdata = cfg_pad[REG_W-1:0];
                A_CFG_HI: bus_rdata = cfg_pad[PAD_W-1:REG_W];
                A_IN:     bus_rdata = REG_W'(in_sync);
                A_OUT:    bus_rdata = REG_W'(st_q.odr);
                A_LOCK:   bus_rdata = {15'd0, locked, 16'(lock_mask)};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = st_q.odr;

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_lkf
            assign lk_fld[g*FIELD_W +: FIELD_W] = {FIELD_W{lock_mask[g]}};
        end
    endgenerate

    // R6
    setclr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_addr == A_SETCLR) |=>
            ((pin_out & $past(set_bits)) == $past(set_bits)));

    // R6
    setclr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_addr == A_SETCLR) |=>
            ((pin_out & $past(clr_bits & ~set_bits)) == '0));

    // R7
    bitclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_addr == A_BITCLR) |=> ((pin_out & $past(set_bits)) == '0));

    // R9
    locked_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ((st_q.cfg & lk_fld) == $past(st_q.cfg & lk_fld)));
endmodule

// File: tb/gpio_port_regs_test.sv
module gpio_port_regs_test;
    import gpio_regs_pkg::*;

    localparam int NPIN = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NPIN-1:0]   pin_in = '0;
    logic [NPIN-1:0]   pin_out, pin_oe, pin_od, pin_alt, pin_pull_en, pin_pull_up;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_port_regs #(.NPIN(NPIN), .SYNC_STAGES(2)) uut (
        .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe), .pin_od (pin_od),
        .pin_alt (pin_alt), .pin_pull_en (pin_pull_en), .pin_pull_up (pin_pull_up)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  a;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd3, 32'h0000A5A5, 32'h0,        4'd5},
        '{1'b0, 3'd3, 32'h0,        32'h0000A5A5, 4'd5},  // R5
        '{1'b1, 3'd4, 32'h00FF0F00, 32'h0,        4'd6},
        '{1'b0, 3'd3, 32'h0,        32'h0000AF00, 4'd6},  // R6
        '{1'b1, 3'd4, 32'h00000000, 32'h0,        4'd6},
        '{1'b0, 3'd3, 32'h0,        32'h0000AF00, 4'd6},  // R6 zeros
        '{1'b1, 3'd4, 32'h000F000F, 32'h0,        4'd6},
        '{1'b0, 3'd3, 32'h0,        32'h0000AF0F, 4'd6},  // R6 set wins
        '{1'b0, 3'd4, 32'h0,        32'h0,        4'd6},
        '{1'b1, 3'd5, 32'h0000A00F, 32'h0,        4'd7},
        '{1'b0, 3'd3, 32'h0,        32'h00000F00, 4'd7},  // R7
        '{1'b0, 3'd5, 32'h0,        32'h0,        4'd7},
        '{1'b1, 3'd0, 32'h12345678, 32'h0,        4'd2},
        '{1'b0, 3'd0, 32'h0,        32'h12345678, 4'd2},  // R2
        '{1'b0, 3'd1, 32'h0,        32'h44444444, 4'd2},
        '{1'b1, 3'd1, 32'hBA98FEDC, 32'h0,        4'd2},
        '{1'b0, 3'd1, 32'h0,        32'hBA98FEDC, 4'd2},
        '{1'b0, 3'd0, 32'h0,        32'h12345678, 4'd2},
        '{1'b0, 3'd7, 32'h0,        32'h0,        4'd1}   // R1 unmapped
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        do_read(a, v);
        chk(req, v, exp);
    endtask

    task automatic lock_seq(input logic [15:0] m);
        do_write(3'd6, {15'd0, 1'b1, m});
        do_write(3'd6, {15'd0, 1'b0, m});
        do_write(3'd6, {15'd0, 1'b1, m});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1", 3'd0, 32'h44444444);
        rd_chk("R1", 3'd1, 32'h44444444);
        rd_chk("R1", 3'd3, 32'h0);
        rd_chk("R1", 3'd6, 32'h0);
        chk("R1", {16'd0, pin_oe}, 32'h0);
        chk("R1", {16'd0, pin_pull_en}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) do_write(VEC[i].a, VEC[i].wd);
            else begin
                do_read(VEC[i].a, rv);
                chk($sformatf("R%0d", VEC[i].req), rv, VEC[i].exp);
            end
        end

        // R3 R4 R5 pin decode
        do_write(3'd0, 32'h4088D951);
        do_write(3'd1, 32'h44444442);
        do_write(3'd3, 32'h00000010);
        chk("R3", {16'd0, pin_oe},      32'h0000010F);
        chk("R3", {16'd0, pin_od},      32'h0000000A);
        chk("R3", {16'd0, pin_alt},     32'h0000000C);
        chk("R4", {16'd0, pin_pull_en}, 32'h00000030);
        chk("R4", {16'd0, pin_pull_up}, 32'h00000010);
        chk("R5", {16'd0, pin_out},     32'h00000010);

        // R8 synchronizer latency
        @(negedge clk);
        pin_in = 16'h8001; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd2;
        #1 chk("R8", bus_rdata, 32'h0);
        @(posedge clk);
        @(negedge clk);
        #1 chk("R8", bus_rdata, 32'h0);
        @(posedge clk);
        #1 chk("R8", bus_rdata, 32'h00008001);
        bus_sel = 1'b0;
        pin_in = 16'hFFFF;
        repeat (2) @(posedge clk);
        rd_chk("R8", 3'd2, 32'h0000FFFF);

        // R10 aborted sequences
        do_write(3'd6, 32'h00010003);
        do_write(3'd6, 32'h00000001);
        do_write(3'd6, 32'h00010003);
        rd_chk("R10", 3'd6, 32'h0);
        do_write(3'd6, 32'h00010003);
        rd_chk("R10", 3'd3, 32'h00000010);
        do_write(3'd6, 32'h00000003);
        do_write(3'd6, 32'h00010003);
        rd_chk("R10", 3'd6, 32'h0);
        do_write(3'd0, 32'h44444421);
        rd_chk("R10", 3'd0, 32'h44444421);

        // R9 lock pins 0 and 1
        lock_seq(16'h0003);
        rd_chk("R9", 3'd6, 32'h00010003);
        do_write(3'd0, 32'hFFFFFFFF);
        rd_chk("R9", 3'd0, 32'hFFFFFF21);
        chk("R9", {16'd0, pin_oe}, 32'h000001FF);

        // R11 lock is sticky
        lock_seq(16'h00FC);
        rd_chk("R11", 3'd6, 32'h00010003);
        do_write(3'd0, 32'h00000000);
        rd_chk("R11", 3'd0, 32'h00000021);

        // R11 reset clears lock
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R11", 3'd6, 32'h0);
        rd_chk("R1", 3'd0, 32'h44444444);
        do_write(3'd0, 32'h00000000);
        rd_chk("R11", 3'd0, 32'h00000000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule